// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit sits between a 32-bit core and a word-wide data memory. A request from the core carries an opcode, a base register value, a 16-bit displacement and, for stores, the register value to be written. The unit adds the sign-extended displacement to the base to form the byte address. For stores it builds a byte-lane write strobe and copies the narrow data item into every lane it could land in. For loads it remembers the size, signedness and lane of the access. When the memory word comes back, it selects the addressed byte or halfword and extends it to 32 bits.

A halfword at an odd address, or a word whose address is not a multiple of four, is refused. The unit raises a flag, issues nothing to memory and consumes the request. Three interfaces carry data and follow valid/ready rules: request in, memory access out, and load result out. The memory's returned word enters on a fourth valid/ready pair. A request completes on a cycle where both valid and ready are high. A source must hold its payload stable while valid is high and ready is low. Only one load may be outstanding at a time: once a load has been issued, new requests stall until the core has taken the load result. The misaligned flag is a plain level output.

Top module: `lsu_align_unit`

## Requirements
- R1: The memory address equals the base plus the 16-bit displacement sign-extended to 32 bits. It is a combinational function of the current request.
- R2: Recognised opcodes are 0x20 signed byte load, 0x21 signed halfword load, 0x23 word load, 0x24 unsigned byte load, 0x25 unsigned halfword load, 0x28 byte store, 0x29 halfword store and 0x2B word store. Any other opcode is consumed (req_ready high), issues no memory access and does not raise the misaligned flag.
- R3: A store drives mem_we high. Its strobe (bit n = byte lane n, lane n = data bits 8n+7..8n, little-endian) is as follows. A byte store has only the bit selected by address bits [1:0] set. A halfword store gives 0011 when address bit 1 is 0 and 1100 when it is 1. A word store gives 1111.
- R4: Store write data is replicated. A byte store puts bits 7..0 of the store value in all four lanes. A halfword store puts bits 15..0 in both halves. A word store passes the value unchanged.
- R5: A load drives mem_we low and a strobe of 0000.
- R6: A signed byte or halfword load returns the selected lane(s) sign-extended to 32 bits.
- R7: An unsigned byte or halfword load returns the selected lane(s) zero-extended. A word load returns the whole memory word.
- R8: A halfword access with address bit 0 set, or a word access with address bits [1:0] nonzero, raises misaligned while the request is valid. It keeps mem_valid low and the strobe at zero, and the request is consumed.
- R9: After a load is accepted by memory, mem_valid and req_ready stay low until the load result is taken. ld_valid follows rdat_valid only while a load is outstanding, and rdat_ready follows ld_ready then.
- R10: For an aligned, recognised request with no load outstanding, mem_valid follows req_valid and req_ready follows mem_ready. After reset no load is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_opcode | input | 6 | Access opcode |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store value |
| misaligned | output | 1 | Current request is misaligned |
| mem_valid | output | 1 | Memory access valid |
| mem_ready | input | 1 | Memory accepts access |
| mem_addr | output | 32 | Byte address |
| mem_we | output | 1 | Write enable |
| mem_strb | output | 4 | Byte-lane write strobe |
| mem_wdata | output | 32 | Replicated write data |
| rdat_valid | input | 1 | Memory read word valid |
| rdat_ready | output | 1 | Read word taken |
| rdat_word | input | 32 | Memory read word |
| ld_valid | output | 1 | Load result valid |
| ld_ready | input | 1 | Core takes load result |
| ld_data | output | 32 | Extended load result |

## Verification
Several rules are checked by the assertions on every cycle. A misaligned request never reaches memory, and loads never carry a strobe. A store strobe always has one, two or four bits set. Nothing is issued in the cycle after a load is accepted, and a load result never appears without a memory word behind it. Only the directed scenarios can show the values themselves: the effective address for negative displacements, the chosen lane for each offset, the replicated store data, and the sign or zero fill of each load flavour. These are compared against constants worked out from the requirements.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int OPC_W = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      known;
    logic      is_store;
    logic      sext;
    acc_size_e size;
  } acc_ctl_t;

  localparam logic [OPC_W-1:0] OPC_LD_B  = 6'h20;
  localparam logic [OPC_W-1:0] OPC_LD_H  = 6'h21;
  localparam logic [OPC_W-1:0] OPC_LD_W  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_LD_BU = 6'h24;
  localparam logic [OPC_W-1:0] OPC_LD_HU = 6'h25;
  localparam logic [OPC_W-1:0] OPC_ST_B  = 6'h28;
  localparam logic [OPC_W-1:0] OPC_ST_H  = 6'h29;
  localparam logic [OPC_W-1:0] OPC_ST_W  = 6'h2B;
endpackage

// File: rtl/lsu_opdecode.sv
module lsu_opdecode
  import lsu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output acc_ctl_t         ctl
);
  always_comb begin
    ctl = '{known: 1'b1, is_store: 1'b0, sext: 1'b0, size: SZ_WORD};
    case (opcode)
      OPC_LD_B:  begin ctl.size = SZ_BYTE; ctl.sext = 1'b1; end
      OPC_LD_H:  begin ctl.size = SZ_HALF; ctl.sext = 1'b1; end
      OPC_LD_W:  ctl.size = SZ_WORD;
      OPC_LD_BU: ctl.size = SZ_BYTE;
      OPC_LD_HU: ctl.size = SZ_HALF;
      OPC_ST_B:  begin ctl.size = SZ_BYTE; ctl.is_store = 1'b1; end
      OPC_ST_H:  begin ctl.size = SZ_HALF; ctl.is_store = 1'b1; end
      OPC_ST_W:  begin ctl.size = SZ_WORD; ctl.is_store = 1'b1; end
      default:   ctl.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_lane_gen.sv
module lsu_lane_gen
  import lsu_pkg::*;
#(
  parameter int XLEN  = 32,
  localparam int NL   = XLEN / 8,
  localparam int OFFW = $clog2(NL)
) (
  input  acc_ctl_t          ctl,
  input  logic [OFFW-1:0]   off,
  input  logic [XLEN-1:0]   wsrc,
  output logic [NL-1:0]     strb,
  output logic [XLEN-1:0]   wrep,
  output logic              misal
);
  always_comb begin
    unique case (ctl.size)
      SZ_BYTE: misal = 1'b0;
      SZ_HALF: misal = off[0];
      default: misal = (off != '0);
    endcase
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    localparam logic [OFFW-1:0] LIDX = OFFW'(g);
    always_comb begin
      unique case (ctl.size)
        SZ_BYTE: begin
          strb[g]          = (off == LIDX);
          wrep[8*g +: 8]   = wsrc[7:0];
        end
        SZ_HALF: begin
          strb[g]          = (off[OFFW-1:1] == LIDX[OFFW-1:1]);
          wrep[8*g +: 8]   = wsrc[8*(g%2) +: 8];
        end
        default: begin
          strb[g]          = 1'b1;
          wrep[8*g +: 8]   = wsrc[8*g +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int XLEN  = 32,
  localparam int NL   = XLEN / 8,
  localparam int OFFW = $clog2(NL)
) (
  input  acc_ctl_t          ctl,
  input  logic [OFFW-1:0]   off,
  input  logic [XLEN-1:0]   word,
  output logic [XLEN-1:0]   result
);
  logic [XLEN-1:0] shifted;
  assign shifted = word >> {off, 3'b000};

  always_comb begin
    unique case (ctl.size)
      SZ_BYTE: result = {{(XLEN-8){ctl.sext & shifted[7]}}, shifted[7:0]};
      SZ_HALF: result = {{(XLEN-16){ctl.sext & shifted[15]}}, shifted[15:0]};
      default: result = word;
    endcase
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DISPW = 16,
  localparam int NL   = XLEN / 8,
  localparam int OFFW = $clog2(NL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OPC_W-1:0]  req_opcode,
  input  logic [XLEN-1:0]   req_base,
  input  logic [DISPW-1:0]  req_disp,
  input  logic [XLEN-1:0]   req_wdata,
  output logic              misaligned,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [XLEN-1:0]   mem_addr,
  output logic              mem_we,
  output logic [NL-1:0]     mem_strb,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              rdat_valid,
  output logic              rdat_ready,
  input  logic [XLEN-1:0]   rdat_word,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [XLEN-1:0]   ld_data
);
  acc_ctl_t        cur_ctl;
  logic [NL-1:0]   lane_strb;
  logic            bad_align;
  logic            refuse;
  logic            pend_q;
  acc_ctl_t        ctx_ctl_q;
  logic [OFFW-1:0] ctx_off_q;

  assign mem_addr = req_base + {{(XLEN-DISPW){req_disp[DISPW-1]}}, req_disp};

  lsu_opdecode u_dec (
    .opcode (req_opcode),
    .ctl    (cur_ctl)
  );

  lsu_lane_gen #(.XLEN(XLEN)) u_lane (
    .ctl   (cur_ctl),
    .off   (mem_addr[OFFW-1:0]),
    .wsrc  (req_wdata),
    .strb  (lane_strb),
    .wrep  (mem_wdata),
    .misal (bad_align)
  );

  assign refuse     = ~cur_ctl.known | bad_align;
  assign misaligned = req_valid & cur_ctl.known & bad_align;
  assign mem_valid  = req_valid & ~refuse & ~pend_q;
  assign req_ready  = refuse | (mem_ready & ~pend_q);
  assign mem_we     = mem_valid & cur_ctl.is_store;
  assign mem_strb   = mem_we ? lane_strb : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      ctx_ctl_q <= '0;
      ctx_off_q <= '0;
    end else if (mem_valid && mem_ready && !cur_ctl.is_store) begin
      pend_q    <= 1'b1;
      ctx_ctl_q <= cur_ctl;
      ctx_off_q <= mem_addr[OFFW-1:0];
    end else if (ld_valid && ld_ready) begin
      pend_q    <= 1'b0;
    end
  end

  assign ld_valid   = pend_q & rdat_valid;
  assign rdat_ready = pend_q & ld_ready;

  lsu_load_extract #(.XLEN(XLEN)) u_ext (
    .ctl    (ctx_ctl_q),
    .off    (ctx_off_q),
    .word   (rdat_word),
    .result (ld_data)
  );
endmodule

// File: rtl/lsu_align_unit_chk.sv
module lsu_align_unit_chk #(
  parameter int NL = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          misaligned,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [NL-1:0] mem_strb,
  input logic          rdat_valid,
  input logic          ld_valid
);
  // R8
  misalign_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> (!mem_valid && mem_strb == '0 && req_ready));

  // R3
  store_strobe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> ($countones(mem_strb) == 1 ||
                               $countones(mem_strb) == 2 ||
                               $countones(mem_strb) == NL));

  // R5
  load_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we) |-> (mem_strb == '0));

  // R9
  single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_we) |=> !mem_valid);

  // R9
  result_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> rdat_valid);

  // R10
  issue_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> req_valid);
endmodule

bind lsu_align_unit lsu_align_unit_chk #(.NL(NL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .misaligned (misaligned),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_strb   (mem_strb),
  .rdat_valid (rdat_valid),
  .ld_valid   (ld_valid)
);

// File: tb/lsu_align_unit_tb_top.sv
module lsu_align_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_opcode = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic [31:0] req_wdata = '0;
  logic        misaligned;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_strb;
  logic [31:0] mem_wdata;
  logic        rdat_valid = 1'b0;
  logic        rdat_ready;
  logic [31:0] rdat_word = '0;
  logic        ld_valid;
  logic        ld_ready = 1'b0;
  logic [31:0] ld_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  lsu_align_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
    .req_base(req_base), .req_disp(req_disp), .req_wdata(req_wdata),
    .misaligned(misaligned),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_strb(mem_strb), .mem_wdata(mem_wdata),
    .rdat_valid(rdat_valid), .rdat_ready(rdat_ready), .rdat_word(rdat_word),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic drive_req(input logic [5:0] op, input logic [31:0] b,
                           input logic [15:0] d, input logic [31:0] w);
    req_valid = 1'b1; req_opcode = op; req_base = b; req_disp = d; req_wdata = w;
  endtask

  task automatic idle();
    req_valid = 1'b0; mem_ready = 1'b0; rdat_valid = 1'b0; ld_ready = 1'b0;
  endtask

  // R1 R3 R4: one store, checked on the issue cycle
  task automatic t_store(input logic [5:0] op, input logic [31:0] b, input logic [15:0] d,
                         input logic [31:0] w, input logic [31:0] ea,
                         input logic [3:0] strb, input logic [31:0] wd);
    @(negedge clk);
    drive_req(op, b, d, w); mem_ready = 1'b1;
    #1;
    chk("R1 address", mem_addr, ea);
    chk("R3 strobe", {28'd0, mem_strb}, {28'd0, strb});
    chk("R3 write enable", {31'd0, mem_we}, 32'd1);
    chk("R4 write data", mem_wdata, wd);
    chk("R10 issue", {30'd0, mem_valid, req_ready}, 32'd3);
    @(posedge clk);
    @(negedge clk); idle();
  endtask

  // R5 R6 R7 R9: one load with a stalled follow-up request
  task automatic t_load(input logic [5:0] op, input logic [31:0] b, input logic [15:0] d,
                        input logic [31:0] ea, input logic [31:0] word,
                        input logic [31:0] exp, input string req);
    @(negedge clk);
    drive_req(op, b, d, 32'hDEAD_BEEF); mem_ready = 1'b1;
    #1;
    chk("R1 load address", mem_addr, ea);
    chk("R5 load we/strobe", {27'd0, mem_we, mem_strb}, 32'd0);
    chk("R10 load issue", {30'd0, mem_valid, req_ready}, 32'd3);
    @(posedge clk);
    @(negedge clk);
    drive_req(6'h23, 32'h40, 16'h0, 32'h0);
    rdat_valid = 1'b1; rdat_word = word; ld_ready = 1'b0;
    #1;
    chk("R9 stall while outstanding", {30'd0, mem_valid, req_ready}, 32'd0);
    chk("R9 result valid", {30'd0, ld_valid, rdat_ready}, 32'd2);
    chk(req, ld_data, exp);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; ld_ready = 1'b1;
    #1;
    chk("R9 result held", {30'd0, ld_valid, rdat_ready}, 32'd3);
    chk(req, ld_data, exp);
    @(posedge clk);
    @(negedge clk);
    ld_ready = 1'b0;
    #1;
    chk("R9 no result after take", {31'd0, ld_valid}, 32'd0);
    idle();
  endtask

  // R8: misaligned request refused
  task automatic t_misalign(input logic [5:0] op, input logic [31:0] b, input logic [15:0] d);
    @(negedge clk);
    drive_req(op, b, d, 32'h1234_5678); mem_ready = 1'b1;
    #1;
    chk("R8 flag/valid/strobe/ready",
        {26'd0, misaligned, mem_valid, mem_strb == 4'd0, req_ready, 2'b00}, {26'd0, 6'b101100});
    @(posedge clk);
    @(negedge clk); idle();
    #1;
    chk("R8 flag drops", {31'd0, misaligned}, 32'd0);
  endtask

  // R2: unrecognised opcode consumed silently
  task automatic t_unknown(input logic [5:0] op);
    @(negedge clk);
    drive_req(op, 32'h101, 16'h0, 32'h0); mem_ready = 1'b0;
    #1;
    chk("R2 unknown opcode", {29'd0, misaligned, mem_valid, req_ready}, 32'd1);
    @(negedge clk); idle();
  endtask

  // R10: memory back-pressure
  task automatic t_backpressure();
    @(negedge clk);
    drive_req(6'h2B, 32'h300, 16'h4, 32'h0); mem_ready = 1'b0;
    #1;
    chk("R10 back-pressure", {30'd0, mem_valid, req_ready}, 32'd2);
    mem_ready = 1'b1;
    #1;
    chk("R10 release", {30'd0, mem_valid, req_ready}, 32'd3);
    @(posedge clk);
    @(negedge clk); idle();
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rdat_valid = 1'b1;
    #1;
    // R10 R9: after reset nothing outstanding
    chk("R10 reset state", {29'd0, ld_valid, mem_valid, rdat_ready}, 32'd0);
    rdat_valid = 1'b0;

    t_store(6'h28, 32'h1000, 16'hFFFD, 32'hABCD_12F7, 32'h0FFD, 4'b0010, 32'hF7F7_F7F7);
    t_store(6'h28, 32'h2000, 16'h0003, 32'h0000_0055, 32'h2003, 4'b1000, 32'h5555_5555);
    t_store(6'h29, 32'h1000, 16'h0002, 32'hABCD_12F7, 32'h1002, 4'b1100, 32'h12F7_12F7);
    t_store(6'h29, 32'h1004, 16'hFFFC, 32'h0000_8001, 32'h1000, 4'b0011, 32'h8001_8001);
    t_store(6'h2B, 32'h2000, 16'h0008, 32'hCAFE_F00D, 32'h2008, 4'b1111, 32'hCAFE_F00D);

    t_load(6'h20, 32'h500, 16'h0003, 32'h503, 32'h8A7F_C301, 32'hFFFF_FF8A, "R6 lb lane3");
    t_load(6'h24, 32'h500, 16'h0003, 32'h503, 32'h8A7F_C301, 32'h0000_008A, "R7 lbu lane3");
    t_load(6'h20, 32'h504, 16'hFFFC, 32'h500, 32'h8A7F_C301, 32'h0000_0001, "R6 lb lane0");
    t_load(6'h20, 32'h502, 16'h0000, 32'h502, 32'h8A7F_C301, 32'h0000_007F, "R6 lb lane2");
    t_load(6'h21, 32'h500, 16'h0000, 32'h500, 32'h8A7F_C301, 32'hFFFF_C301, "R6 lh half0");
    t_load(6'h21, 32'h500, 16'h0002, 32'h502, 32'h8A7F_C301, 32'hFFFF_8A7F, "R6 lh half1");
    t_load(6'h25, 32'h500, 16'h0002, 32'h502, 32'h8A7F_C301, 32'h0000_8A7F, "R7 lhu half1");
    t_load(6'h23, 32'h100, 16'hFFFC, 32'h0FC, 32'h8A7F_C301, 32'h8A7F_C301, "R7 lw");

    t_misalign(6'h21, 32'h1000, 16'h0001);
    t_misalign(6'h2B, 32'h1000, 16'h0002);
    t_misalign(6'h29, 32'h1003, 16'h0000);
    t_misalign(6'h23, 32'h1004, 16'hFFFD);

    t_unknown(6'h22);
    t_unknown(6'h00);
    t_backpressure();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule